// File: doc/BRIEF.md
# Robbed-Bit Signaling Reinserter

This block rewrites a T1 receive bit stream on the system side so that per-channel ABCD signaling shows up at frame positions that a local multiframe marker chooses, not the received framing. The stream enters one bit per clock in standard T1 order. Each frame is 193 bits: one framing bit, then 24 channels of 8 bits, most significant bit first. Buffered signaling for every channel is held steady at the `sigBits` input. The output is the same stream one clock later. In it, the least significant bit of each selected channel is overwritten in the robbed frames with the signaling bit that belongs to that frame.

A pulse on `mfSync` marks the framing bit of frame 1. After the pulse, an internal bit, channel and frame count runs freely. It wraps every 193 bits and every 24 frames in extended-superframe mode, or every 12 frames in superframe mode. The robbed bits that the line framing already placed in the stream are not located or removed. If they fall elsewhere, they pass through like any other data, and the stream then carries two copies of the signaling. A single enable turns insertion on. A 24-bit mask then chooses the channels, so that data channels can be left untouched.

Top module: `rbsig_reinsert`

## Requirements
- R1: Every output bit that is not a replaced signaling bit equals the input bit from the previous clock, framing bit included.
- R2: The input bit presented together with `mfSync`=1 is the framing bit of frame 1. A later pulse, even in the middle of a frame, restarts the count from that bit.
- R3: With `esfMode`=1, in frames 6, 12, 18 and 24 the 8th (last) bit of each selected channel c is replaced by A, B, C and D respectively. Here A=`sigBits[4c+3]`, B=`sigBits[4c+2]`, C=`sigBits[4c+1]` and D=`sigBits[4c]`, and channel c occupies frame bits 8c+1 to 8c+8.
- R4: With `esfMode`=0 the multiframe is 12 frames. Only frames 6 and 12 are robbed, carrying A and B respectively.
- R5: A robbed bit of channel c is replaced only when `chanMask[c]`=1. Otherwise the input bit passes through.
- R6: With `reinsEn`=0 no bit is replaced.
- R7: After reset and before the first `mfSync` pulse, no bit is replaced.
- R8: While `rst` is high, `serOut` is 0 after each clock edge.
- R9: Without further pulses, the count wraps after bit 193 of every frame and after the last frame of the multiframe. Insertion keeps recurring at the same positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Backplane bit clock, one bit per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| serIn | input | 1 | Incoming serial T1 data |
| mfSync | input | 1 | Multiframe marker, high with the framing bit of frame 1 |
| esfMode | input | 1 | 1 = 24-frame ABCD format, 0 = 12-frame AB format |
| reinsEn | input | 1 | Global insertion enable |
| chanMask | input | 24 | Per-channel insertion select, bit c for channel c |
| sigBits | input | 96 | Buffered signaling, nibble c = {A,B,C,D} of channel c |
| serOut | output | 1 | Serial data with signaling inserted, one clock after input |

## Verification
The checker watches four things on every cycle. It confirms that non-robbed bits and disabled operation give a one-clock copy of the input. It confirms that no slot opens on a marker bit or before the first marker, and that the 12-frame format never selects C or D. It also confirms the reset value. It cannot tell whether the correct nibble bit went to the correct channel in the correct frame. Nor can it tell whether masking, wrapping and mid-frame realignment leave the positions where they should be. Those properties come only from the bench's scenarios compared against its behavioural model.

// File: rtl/rbsig_pkg.sv
package rbsig_pkg;
  localparam int MAX_CH_W = 8;

  typedef struct packed {
    logic                slotHit;
    logic [MAX_CH_W-1:0] chan;
    logic [1:0]          sigSel;
  } strobe_t;
endpackage

// File: rtl/rbsig_ctrl.sv
module rbsig_ctrl
  import rbsig_pkg::*;
#(
  parameter int NUM_CH      = 24,
  parameter int BITS_PER_CH = 8,
  parameter int ROB_PERIOD  = 6,
  parameter int ESF_FRAMES  = 24,
  parameter int D4_FRAMES   = 12
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    mfSync,
  input  logic    esfMode,
  output strobe_t strobe
);
  localparam int FRAME_BITS = NUM_CH * BITS_PER_CH + 1;
  localparam int POS_W      = $clog2(FRAME_BITS);
  localparam int BIT_W      = $clog2(BITS_PER_CH);
  localparam int CH_W       = $clog2(NUM_CH);
  localparam int FR_W       = $clog2(ESF_FRAMES);
  localparam int PH_W       = $clog2(ROB_PERIOD);

  logic [POS_W-1:0] posQ, posE;
  logic [BIT_W-1:0] bitQ, bitE;
  logic [CH_W-1:0]  chQ, chE;
  logic [FR_W-1:0]  frQ, frE, lastFr;
  logic [PH_W-1:0]  phQ, phE;
  logic [1:0]       idxQ, idxE;
  logic             alignQ, alignE, frameEnd;

  // A marker forces the current bit to be the framing bit of frame 1.
  always_comb begin
    if (mfSync) begin
      posE = '0; bitE = '0; chE = '0; frE = '0; phE = '0; idxE = '0;
    end else begin
      posE = posQ; bitE = bitQ; chE = chQ; frE = frQ; phE = phQ; idxE = idxQ;
    end
    alignE   = alignQ | mfSync;
    lastFr   = esfMode ? FR_W'(ESF_FRAMES - 1) : FR_W'(D4_FRAMES - 1);
    frameEnd = (posE == POS_W'(FRAME_BITS - 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      posQ <= '0; bitQ <= '0; chQ <= '0;
      frQ <= '0; phQ <= '0; idxQ <= '0;
      alignQ <= 1'b0;
    end else begin
      alignQ <= alignE;
      if (frameEnd) begin
        posQ <= '0;
        bitQ <= '0;
        chQ  <= '0;
        if (frE >= lastFr) begin
          frQ <= '0; phQ <= '0; idxQ <= '0;
        end else begin
          frQ <= frE + 1'b1;
          if (phE == PH_W'(ROB_PERIOD - 1)) begin
            phQ  <= '0;
            idxQ <= idxE + 1'b1;
          end else begin
            phQ <= phE + 1'b1;
          end
        end
      end else begin
        posQ <= posE + 1'b1;
        if (posE == '0) begin
          bitQ <= '0;
          chQ  <= '0;
        end else if (bitE == BIT_W'(BITS_PER_CH - 1)) begin
          bitQ <= '0;
          chQ  <= chE + 1'b1;
        end else begin
          bitQ <= bitE + 1'b1;
        end
      end
    end
  end

  always_comb begin
    strobe.slotHit = alignE && (posE != '0) &&
                     (bitE == BIT_W'(BITS_PER_CH - 1)) &&
                     (phE == PH_W'(ROB_PERIOD - 1));
    strobe.chan    = MAX_CH_W'(chE);
    strobe.sigSel  = idxE;
  end
endmodule

// File: rtl/rbsig_dp.sv
module rbsig_dp
  import rbsig_pkg::*;
#(
  parameter int NUM_CH = 24
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                serIn,
  input  logic                reinsEn,
  input  logic [NUM_CH-1:0]   chanMask,
  input  logic [4*NUM_CH-1:0] sigBits,
  input  strobe_t             strobe,
  output logic                serOut
);
  logic [NUM_CH-1:0] chHit;
  logic [3:0]        selNib;
  logic              insBit, useIns;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    assign chHit[g] = (strobe.chan == MAX_CH_W'(g)) & chanMask[g];
  end

  always_comb begin
    selNib = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (strobe.chan == MAX_CH_W'(c)) selNib = sigBits[4*c +: 4];
    end
    insBit = selNib[2'd3 - strobe.sigSel];
    useIns = strobe.slotHit & reinsEn & (|chHit);
  end

  always_ff @(posedge clk) begin
    if (rst) serOut <= 1'b0;
    else     serOut <= useIns ? insBit : serIn;
  end
endmodule

// File: rtl/rbsig_reinsert.sv
module rbsig_reinsert
  import rbsig_pkg::*;
#(
  parameter int NUM_CH      = 24,
  parameter int BITS_PER_CH = 8,
  parameter int ROB_PERIOD  = 6,
  parameter int ESF_FRAMES  = 24,
  parameter int D4_FRAMES   = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                serIn,
  input  logic                mfSync,
  input  logic                esfMode,
  input  logic                reinsEn,
  input  logic [NUM_CH-1:0]   chanMask,
  input  logic [4*NUM_CH-1:0] sigBits,
  output logic                serOut
);
  strobe_t strobe;

  rbsig_ctrl #(
    .NUM_CH(NUM_CH), .BITS_PER_CH(BITS_PER_CH), .ROB_PERIOD(ROB_PERIOD),
    .ESF_FRAMES(ESF_FRAMES), .D4_FRAMES(D4_FRAMES)
  ) ctrl_i (
    .clk(clk), .rst(rst), .mfSync(mfSync), .esfMode(esfMode), .strobe(strobe)
  );

  rbsig_dp #(.NUM_CH(NUM_CH)) dp_i (
    .clk(clk), .rst(rst), .serIn(serIn), .reinsEn(reinsEn),
    .chanMask(chanMask), .sigBits(sigBits), .strobe(strobe), .serOut(serOut)
  );
endmodule

// File: rtl/rbsig_reinsert_chk.sv
module rbsig_reinsert_chk
  import rbsig_pkg::*;
(
  input logic    clk,
  input logic    rst,
  input logic    serIn,
  input logic    mfSync,
  input logic    esfMode,
  input logic    reinsEn,
  input logic    serOut,
  input strobe_t strobe
);
  logic seenSync;

  always_ff @(posedge clk) begin
    if (rst)         seenSync <= 1'b0;
    else if (mfSync) seenSync <= 1'b1;
  end

  assert_passthru_R1: assert property (@(posedge clk) disable iff (rst)
    !strobe.slotHit |=> serOut == $past(serIn));

  assert_sync_fbit_R2: assert property (@(posedge clk) disable iff (rst)
    mfSync |-> !strobe.slotHit);

  assert_d4_ab_only_R4: assert property (@(posedge clk) disable iff (rst)
    (!esfMode && strobe.slotHit) |-> strobe.sigSel < 2'd2);

  assert_disabled_R6: assert property (@(posedge clk) disable iff (rst)
    !reinsEn |=> serOut == $past(serIn));

  assert_presync_R7: assert property (@(posedge clk) disable iff (rst)
    (!seenSync && !mfSync) |-> !strobe.slotHit);

  assert_reset_out_R8: assert property (@(posedge clk)
    $past(rst) |-> serOut == 1'b0);
endmodule

bind rbsig_reinsert rbsig_reinsert_chk chk_i (
  .clk(clk), .rst(rst), .serIn(serIn), .mfSync(mfSync), .esfMode(esfMode),
  .reinsEn(reinsEn), .serOut(serOut), .strobe(strobe)
);

// File: tb/rbsig_reinsert_tb_top.sv
module rbsig_reinsert_tb_top;
  localparam int NUM_CH     = 24;
  localparam int FRAME_BITS = 193;

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic                serIn = 1'b0, mfSync = 1'b0, esfMode = 1'b1, reinsEn = 1'b0;
  logic [NUM_CH-1:0]   chanMask = '0;
  logic [4*NUM_CH-1:0] sigBits = '0;
  logic                serOut;

  always #2 clk = ~clk;

  rbsig_reinsert dut_i (
    .clk(clk), .rst(rst), .serIn(serIn), .mfSync(mfSync), .esfMode(esfMode),
    .reinsEn(reinsEn), .chanMask(chanMask), .sigBits(sigBits), .serOut(serOut)
  );

  int    checks = 0, fails = 0;
  int    mPos = 0, mFrame = 0;
  bit    mAligned = 0, expVal = 0, expValid = 0, done = 0;
  string expTag = "", phaseTag = "";

  // Called at a falling edge: check the last prediction, drive, predict.
  task automatic step(input bit d, input bit s);
    int ep, ef, ch, k;
    bit ex, lsbSlot;
    string tag;
    if (expValid) begin
      checks++;
      if (serOut !== expVal) begin
        fails++;
        $display("FAIL %s: serOut=%0b expected %0b at %0t", expTag, serOut, expVal, $time);
      end
    end
    serIn  = d;
    mfSync = s;
    if (s) begin ep = 0; ef = 0; mAligned = 1; end
    else   begin ep = mPos; ef = mFrame; end
    ex  = d;
    tag = "R1";
    lsbSlot = (ep > 0) && ((ep - 1) % 8 == 7) && ((ef + 1) % 6 == 0);
    if (lsbSlot && !mAligned) tag = "R7";
    if (lsbSlot && mAligned) begin
      ch  = (ep - 1) / 8;
      k   = (ef + 1) / 6 - 1;
      tag = (phaseTag != "") ? phaseTag : (esfMode ? "R3" : "R4");
      if (reinsEn && chanMask[ch]) ex = sigBits[4*ch + 3 - k];
    end
    mPos = ep + 1;
    if (mPos == FRAME_BITS) begin
      mPos   = 0;
      mFrame = ef + 1;
      if (mFrame >= (esfMode ? 24 : 12)) mFrame = 0;
    end
    expVal = ex; expTag = tag; expValid = 1;
    @(negedge clk);
  endtask

  task automatic runBits(input int n, input bit forceOnes);
    for (int i = 0; i < n; i++) step(forceOnes ? 1'b1 : 1'($urandom % 2), 1'b0);
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete");
      report();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++; // R8: output held at zero during reset
    if (serOut !== 1'b0) begin
      fails++;
      $display("FAIL R8: serOut=%0b expected 0", serOut);
    end
    rst = 1'b0;

    // R7: enabled and fully selected but no marker yet
    reinsEn = 1'b1; chanMask = '1; esfMode = 1'b1;
    sigBits = {$urandom, $urandom, $urandom};
    phaseTag = "R7";
    runBits(7 * FRAME_BITS, 1'b0);

    // R3: extended format, all channels, two multiframes
    phaseTag = "";
    step(1'($urandom % 2), 1'b1);
    runBits(2 * 24 * FRAME_BITS - 1, 1'b0);

    // R9: free running with no further marker
    phaseTag = "R9";
    sigBits = {$urandom, $urandom, $urandom};
    runBits(24 * FRAME_BITS, 1'b0);

    // R5: a partial channel mask
    phaseTag = "R5";
    chanMask = 24'h5A3C81;
    step(1'($urandom % 2), 1'b1);
    runBits(24 * FRAME_BITS, 1'b0);

    // R6: global enable off
    phaseTag = "R6";
    reinsEn = 1'b0;
    runBits(24 * FRAME_BITS, 1'b0);

    // R4: 12-frame format, mode switched together with a marker
    phaseTag = "";
    reinsEn = 1'b1; chanMask = '1; esfMode = 1'b0;
    sigBits = {$urandom, $urandom, $urandom};
    step(1'($urandom % 2), 1'b1);
    runBits(3 * 12 * FRAME_BITS, 1'b0);

    // R2: marker arriving in mid-frame realigns the count
    phaseTag = "R2";
    esfMode = 1'b1;
    step(1'($urandom % 2), 1'b1);
    runBits(1000, 1'b0);
    step(1'($urandom % 2), 1'b1);
    runBits(24 * FRAME_BITS, 1'b0);

    // R3: all-ones data against all-zero signaling
    phaseTag = "";
    sigBits = '0;
    step(1'b1, 1'b1);
    runBits(24 * FRAME_BITS, 1'b1);

    step(1'b0, 1'b0);
    done = 1;
    report();
  end
endmodule